// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Controller with Rewind

The block is a first-in first-out store whose writer and reader each run on their own clock. It holds the storage array, both address pointers, the output register and the fill indications. Each pointer crosses into the other clock domain as a Gray code through a two-stage synchroniser. Because of this, a flag can be released late but is never raised late.

The output behaviour is picked while the full reset is held. In standard mode a word reaches `dout` only when it is read. In fall-through mode the oldest word is moved into the output register without any read request. That extra register lets the block hold one more word than the array depth. The read-status and write-status pins swap their polarity with the mode.

A data reset empties the store but keeps the chosen mode. A `rewind` pulse moves the read side back to the first word written since the last reset, so that word sequence can be replayed. A rewind is legal only when no more than DEPTH-2 words were written since that reset, so the store is never full while a rewind is in progress.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `full_rst` is high on a write and a read clock edge, both pointers return to the first location and the block shows an empty store. `half_full_n` reads 1. In standard mode `rd_status`=0 and `wr_status`=1; in fall-through mode `rd_status`=1 and `wr_status`=0. The mode is taken from `fwft_sel` (0 = standard, 1 = fall-through) while `full_rst` is high.
- R2: In standard mode `rd_status`=1 means words are available and 0 means empty. A word written on write edge k raises `rd_status` after read edge k+2.
- R3: In standard mode, a read clock edge with `ren`=1 and `rd_status`=1 loads the oldest stored word into `dout` at that edge.
- R4: In standard mode the store holds DEPTH words. `wr_status` drops to 0 right after the write edge of the DEPTH-th unread word.
- R5: From full, one read at read edge r releases the full indication after write edge r+2. In standard mode that means `wr_status` goes back to 1; in fall-through mode it goes back to 0.
- R6: A write while full and a read while empty are ignored. Neither pointer moves, and the words that follow come out intact and in order.
- R7: In fall-through mode `rd_status`=0 marks a valid `dout`. The first word written into an empty store on write edge k appears on `dout`, with `rd_status`=0, after read edge k+3 without any `ren`. A read edge with `ren`=1 and `rd_status`=0 consumes the shown word.
- R8: In fall-through mode the block holds DEPTH+1 words. Once the first word has moved to the output, `wr_status` stays 0 through DEPTH further writes in total minus one, and rises to 1 after the DEPTH-th further write.
- R9: `half_full_n` is 0 exactly while the number of written words not yet taken into the output path exceeds DEPTH/2.
- R10: `data_rst` empties the store and returns both pointers to the first location, but keeps the mode chosen at the last full reset.
- R11: In standard mode, a `rewind` pulse seen at read edge e forces `rd_status` to 0 after edge e. After edge e+1 reading restarts from the first word written since the last reset.
- R12: In fall-through mode, a `rewind` pulse seen at read edge e holds `rd_status` at 1 after edges e and e+1. After edge e+2, `rd_status` is 0 and the first word written since the last reset is on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| full_rst | input | 1 | Full reset, synchronous and active high; also samples the mode |
| data_rst | input | 1 | Data reset, synchronous and active high; keeps the mode |
| fwft_sel | input | 1 | Mode choice sampled during full reset: 0 standard, 1 fall-through |
| wen | input | 1 | Write request |
| din | input | DATA_W (18) | Write data |
| ren | input | 1 | Read request |
| rewind | input | 1 | Restart reading from the first word since reset |
| dout | output | DATA_W (18) | Output register |
| rd_status | output | 1 | Standard: 1 = data available; fall-through: 0 = dout valid |
| wr_status | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| half_full_n | output | 1 | 0 while more than DEPTH/2 words are stored |

## Verification
Both clocks run with the same period and phase, so every result has a fixed edge count. The full indication changes right after the write edge that fills the store. It is released two edges after a read, and the available indication rises two edges after a write. A fall-through word is shown three edges after it is written. A rewind shows its setup state for one edge in standard mode and for two edges in fall-through mode. Inputs change on falling edges, and each flag is checked on the falling edge right after the edge where it is due and also on the edge before, so an early or late flag is caught. A monitor compares `dout` against a queue of expected words half a cycle after each consuming read edge, and on a rewind the queue is refilled from the history of words written since reset.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    localparam int WORD_W_DEF = 18;
    localparam int GRAY_W     = 32;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // read-side control state
    typedef struct packed {
        logic valid;   // fall-through output register holds a word
        logic busy;    // rewind setup in progress
    } rd_ctl_t;

    function automatic logic [GRAY_W-1:0] to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] from_gray(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (clr) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (clr) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/fifo_rt_wside.sv
module fifo_rt_wside
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              full_rst,
    input  logic              data_rst,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [PTR_W-1:0]  rgray_sync,
    output logic [PTR_W-1:0]  wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              mem_we,
    output fifo_mode_e        mode,
    output logic [PTR_W-1:0]  fill,
    output logic              full,
    output logic              half
);
    logic [PTR_W-1:0] wbin, wbin_nxt, rbin_sync;

    assign rbin_sync = PTR_W'(from_gray(GRAY_W'(rgray_sync)));
    assign fill      = wbin - rbin_sync;
    assign full      = (fill == PTR_W'(DEPTH));
    assign half      = (fill > PTR_W'(DEPTH / 2));
    assign mem_we    = wen && !full;
    assign wbin_nxt  = wbin + PTR_W'(1);
    assign waddr     = wbin[ADDR_W-1:0];

    always_ff @(posedge wclk) begin
        if (full_rst || data_rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_nxt;
            wgray <= PTR_W'(to_gray(GRAY_W'(wbin_nxt)));
        end
    end

    always_ff @(posedge wclk) begin
        if (full_rst) mode <= fwft_sel ? MODE_FWFT : MODE_STD;
    end
endmodule

// File: rtl/fifo_rt_rside.sv
module fifo_rt_rside
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              full_rst,
    input  logic              data_rst,
    input  logic              fwft_sel,
    input  logic              ren,
    input  logic              rewind,
    input  logic [PTR_W-1:0]  wgray_sync,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rgray,
    output logic [DATA_W-1:0] dout,
    output fifo_mode_e        mode,
    output logic              ram_empty,
    output logic              rd_status
);
    logic [PTR_W-1:0] rbin, rbin_nxt, wbin_sync;
    rd_ctl_t          ctl;
    logic             std_fire, fwft_load, advance;

    assign wbin_sync = PTR_W'(from_gray(GRAY_W'(wgray_sync)));
    assign ram_empty = (rbin == wbin_sync);
    assign rbin_nxt  = rbin + PTR_W'(1);
    assign raddr     = rbin[ADDR_W-1:0];

    assign std_fire  = ren && !ram_empty && !ctl.busy;
    assign fwft_load = !ram_empty && !ctl.busy && (!ctl.valid || ren);
    assign advance   = (mode == MODE_FWFT) ? fwft_load : std_fire;

    always_ff @(posedge rclk) begin
        if (full_rst || data_rst) begin
            rbin  <= '0;
            rgray <= '0;
            ctl   <= '0;
            dout  <= '0;
        end else if (rewind) begin
            rbin      <= '0;
            rgray     <= '0;
            ctl.valid <= 1'b0;
            ctl.busy  <= 1'b1;
        end else begin
            ctl.busy <= 1'b0;
            if (advance) begin
                rbin  <= rbin_nxt;
                rgray <= PTR_W'(to_gray(GRAY_W'(rbin_nxt)));
                dout  <= rdata;
            end
            if (mode == MODE_FWFT) begin
                if (fwft_load)  ctl.valid <= 1'b1;
                else if (ren)   ctl.valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (full_rst) mode <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    assign rd_status = (mode == MODE_FWFT) ? !ctl.valid : !(ram_empty || ctl.busy);
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
    import fifo_rt_pkg::*;
#(
    parameter int DATA_W = WORD_W_DEF,
    parameter int DEPTH  = 16
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              full_rst,
    input  logic              data_rst,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              rewind,
    output logic [DATA_W-1:0] dout,
    output logic              rd_status,
    output logic              wr_status,
    output logic              half_full_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic [PTR_W-1:0]  w_gray, r_gray, w_gray_s, r_gray_s, w_fill;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic [DATA_W-1:0] r_data;
    logic              w_we, w_full, w_half, r_empty;
    fifo_mode_e        w_mode, r_mode;
    logic              any_rst;

    assign any_rst = full_rst || data_rst;

    fifo_rt_wside #(.DEPTH(DEPTH)) u_wside (
        .wclk(wclk), .full_rst(full_rst), .data_rst(data_rst), .fwft_sel(fwft_sel),
        .wen(wen), .rgray_sync(r_gray_s), .wgray(w_gray), .waddr(w_addr),
        .mem_we(w_we), .mode(w_mode), .fill(w_fill), .full(w_full), .half(w_half)
    );

    fifo_rt_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(w_we), .waddr(w_addr), .wdata(din),
        .raddr(r_addr), .rdata(r_data)
    );

    fifo_rt_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .clr(any_rst), .d(w_gray), .q(w_gray_s));
    fifo_rt_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .clr(any_rst), .d(r_gray), .q(r_gray_s));

    fifo_rt_rside #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rside (
        .rclk(rclk), .full_rst(full_rst), .data_rst(data_rst), .fwft_sel(fwft_sel),
        .ren(ren), .rewind(rewind), .wgray_sync(w_gray_s), .rdata(r_data),
        .raddr(r_addr), .rgray(r_gray), .dout(dout), .mode(r_mode),
        .ram_empty(r_empty), .rd_status(rd_status)
    );

    assign wr_status   = (w_mode == MODE_FWFT) ? w_full : !w_full;
    assign half_full_n = !w_half;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             wclk,
    input logic             rclk,
    input logic             full_rst,
    input logic             data_rst,
    input logic             wen,
    input logic             rewind,
    input logic             rd_status,
    input logic             half_full_n,
    input logic             wr_full,
    input logic [PTR_W-1:0] wr_fill,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray,
    input logic             rd_ram_empty,
    input fifo_mode_e       rd_mode
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (full_rst || data_rst)
        wr_fill <= PTR_W'(DEPTH)); // R8

    AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (full_rst || data_rst)
        (wr_full && wen) |=> $stable(wgray)); // R6

    AST_EMPTY_READ_DROPPED: assert property (@(posedge rclk) disable iff (full_rst || data_rst)
        (rd_ram_empty && !rewind) |=> $stable(rgray)); // R6

    AST_FULL_IMPLIES_HALF: assert property (@(posedge wclk) disable iff (full_rst || data_rst)
        wr_full |-> !half_full_n); // R9

    AST_REWIND_STD_EMPTY: assert property (@(posedge rclk) disable iff (full_rst || data_rst)
        (rewind && rd_mode == MODE_STD) |=> !rd_status); // R11

    AST_REWIND_FWFT_INVALID: assert property (@(posedge rclk) disable iff (full_rst || data_rst)
        (rewind && rd_mode == MODE_FWFT) |=> rd_status); // R12
endmodule

bind fifo_rt_ctrl fifo_rt_chk #(.DEPTH(DEPTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .full_rst(full_rst), .data_rst(data_rst),
    .wen(wen), .rewind(rewind), .rd_status(rd_status), .half_full_n(half_full_n),
    .wr_full(w_full), .wr_fill(w_fill), .wgray(w_gray), .rgray(r_gray),
    .rd_ram_empty(r_empty), .rd_mode(r_mode)
);

// File: tb/fifo_rt_ctrl_test.sv
module fifo_rt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 18;
    localparam int DEPTH      = 16;
    localparam int WDOG       = 20000;

    logic wclk = 1'b0, rclk = 1'b0;
    logic full_rst = 1'b1, data_rst = 1'b0, fwft_sel = 1'b0;
    logic wen = 1'b0, ren = 1'b0, rewind = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic rd_status, wr_status, half_full_n;

    int  n_checks = 0, n_fails = 0;
    bit  done = 1'b0;
    bit  cur_fwft = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] hist[$];

    fifo_rt_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .full_rst(full_rst), .data_rst(data_rst),
        .fwft_sel(fwft_sel), .wen(wen), .din(din), .ren(ren), .rewind(rewind),
        .dout(dout), .rd_status(rd_status), .wr_status(wr_status),
        .half_full_n(half_full_n)
    );

    initial forever #(CLK_PERIOD/2) wclk = ~wclk;
    initial forever #(CLK_PERIOD/2) rclk = ~rclk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge wclk);
    endtask

    task automatic push_words(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen = 1'b1;
            din = DW'(seed + i * 7);
            exp_q.push_back(din);
            hist.push_back(din);
        end
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic write_blocked(input logic [DW-1:0] v);
        @(negedge wclk);
        wen = 1'b1;
        din = v;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic drain(input int n);
        @(negedge wclk);
        ren = 1'b1;
        repeat (n) @(negedge wclk);
        ren = 1'b0;
        tick(2);
    endtask

    task automatic do_full_reset(input bit m);
        @(negedge wclk);
        full_rst = 1'b1;
        fwft_sel = m;
        tick(3);
        full_rst = 1'b0;
        cur_fwft = m;
        exp_q.delete();
        hist.delete();
    endtask

    // monitor: scoreboard compare of consumed words
    always begin : monitor
        bit pend;
        logic [DW-1:0] e;
        pend = 1'b0;
        forever begin
            @(negedge wclk);
            #2;
            if (pend) begin
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                check(dout === e, "R3 std read data", 32'(dout), 32'(e));
            end
            pend = 1'b0;
            if (!full_rst && !data_rst) begin
                if (!cur_fwft) begin
                    pend = ren && rd_status;
                end else if (ren && !rd_status) begin
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                    check(dout === e, "R7 fall-through read data", 32'(dout), 32'(e));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (WDOG) @(posedge wclk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        // ---- standard mode ----
        tick(3);
        full_rst = 1'b0;
        do_full_reset(1'b0);
        check(rd_status == 1'b0, "R1 std empty", 32'(rd_status), 0);
        check(wr_status == 1'b1, "R1 std not full", 32'(wr_status), 1);
        check(half_full_n == 1'b1, "R1 half inactive", 32'(half_full_n), 1);

        push_words(1, 'h011);                       // after edge k
        check(rd_status == 1'b0, "R2 not yet at k", 32'(rd_status), 0);
        tick(1);
        check(rd_status == 1'b0, "R2 not yet at k+1", 32'(rd_status), 0);
        tick(1);
        check(rd_status == 1'b1, "R2 available at k+2", 32'(rd_status), 1);
        drain(2);
        check(exp_q.size() == 0, "R3 word consumed", exp_q.size(), 0);

        drain(3);                                   // reads on empty: ignored
        push_words(1, 'h2A5);
        tick(2);
        drain(3);
        check(exp_q.size() == 0, "R6 empty read ignored", exp_q.size(), 0);
        check(rd_status == 1'b0, "R6 empty again", 32'(rd_status), 0);

        do_full_reset(1'b0);
        push_words(DEPTH/2, 'h100);
        check(half_full_n == 1'b1, "R9 at half", 32'(half_full_n), 1);
        push_words(1, 'h180);
        check(half_full_n == 1'b0, "R9 above half", 32'(half_full_n), 0);
        push_words(DEPTH/2 - 2, 'h200);
        check(wr_status == 1'b1, "R4 not full at D-1", 32'(wr_status), 1);
        push_words(1, 'h280);
        check(wr_status == 1'b0, "R4 full at D", 32'(wr_status), 0);
        write_blocked(18'h3DEAD);
        check(wr_status == 1'b0, "R6 still full", 32'(wr_status), 0);
        tick(2);
        @(negedge wclk); ren = 1'b1;
        @(negedge wclk); ren = 1'b0;                // after read edge r
        check(wr_status == 1'b0, "R5 full at r", 32'(wr_status), 0);
        tick(1);
        check(wr_status == 1'b0, "R5 full at r+1", 32'(wr_status), 0);
        tick(1);
        check(wr_status == 1'b1, "R5 released at r+2", 32'(wr_status), 1);
        drain(DEPTH + 2);
        check(exp_q.size() == 0, "R6 full write ignored", exp_q.size(), 0);

        // ---- fall-through mode ----
        do_full_reset(1'b1);
        check(rd_status == 1'b1, "R1 fwft empty", 32'(rd_status), 1);
        check(wr_status == 1'b0, "R1 fwft not full", 32'(wr_status), 0);
        push_words(1, 'h055);                       // after edge k
        tick(2);
        check(rd_status == 1'b1, "R7 not valid at k+2", 32'(rd_status), 1);
        tick(1);
        check(rd_status == 1'b0, "R7 valid at k+3", 32'(rd_status), 0);
        check(dout == hist[0], "R7 word shown", 32'(dout), 32'(hist[0]));
        tick(3);
        push_words(DEPTH - 1, 'h300);
        check(wr_status == 1'b0, "R8 not full at D", 32'(wr_status), 0);
        push_words(1, 'h3F0);
        check(wr_status == 1'b1, "R8 full at D+1", 32'(wr_status), 1);
        write_blocked(18'h1BEEF);
        check(wr_status == 1'b1, "R8 still full", 32'(wr_status), 1);
        tick(2);
        @(negedge wclk); ren = 1'b1;
        @(negedge wclk); ren = 1'b0;
        tick(1);
        check(wr_status == 1'b1, "R5 fwft full at r+1", 32'(wr_status), 1);
        tick(1);
        check(wr_status == 1'b0, "R5 fwft released at r+2", 32'(wr_status), 0);
        drain(DEPTH + 4);
        check(exp_q.size() == 0, "R8 all D+1 words out", exp_q.size(), 0);

        push_words(3, 'h0A0);
        tick(4);
        @(negedge wclk); data_rst = 1'b1;
        tick(2);
        data_rst = 1'b0;
        exp_q.delete();
        hist.delete();
        check(rd_status == 1'b1, "R10 empty, mode kept", 32'(rd_status), 1);
        check(wr_status == 1'b0, "R10 not full, mode kept", 32'(wr_status), 0);

        push_words(5, 'h0C1);
        tick(3);
        check(dout == hist[0], "R10 fall-through after data reset", 32'(dout), 32'(hist[0]));
        @(negedge wclk); ren = 1'b1;
        tick(2);
        ren = 1'b0;
        tick(1);
        @(negedge wclk); rewind = 1'b1;
        exp_q = hist;
        @(negedge wclk); rewind = 1'b0;             // after edge e
        check(rd_status == 1'b1, "R12 setup at e", 32'(rd_status), 1);
        tick(1);
        check(rd_status == 1'b1, "R12 setup at e+1", 32'(rd_status), 1);
        tick(1);
        check(rd_status == 1'b0, "R12 ready at e+2", 32'(rd_status), 0);
        check(dout == hist[0], "R12 first word", 32'(dout), 32'(hist[0]));
        drain(8);
        check(exp_q.size() == 0, "R12 replay complete", exp_q.size(), 0);

        // ---- standard rewind ----
        do_full_reset(1'b0);
        push_words(4, 'h0E3);
        tick(3);
        @(negedge wclk); ren = 1'b1;
        tick(2);
        ren = 1'b0;
        tick(1);
        @(negedge wclk); rewind = 1'b1;
        exp_q = hist;
        @(negedge wclk); rewind = 1'b0;             // after edge e
        check(rd_status == 1'b0, "R11 setup at e", 32'(rd_status), 0);
        tick(1);
        check(rd_status == 1'b1, "R11 ready at e+1", 32'(rd_status), 1);
        drain(6);
        check(exp_q.size() == 0, "R11 replay complete", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule